// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block is the address unit of a processor bus interface. It keeps four 16-bit segment bases (code, stack, data and extra) and turns a 16-bit offset into a 20-bit physical byte address. The base is moved up by one hex digit and the offset is added to it. The sum wraps within the 1 MB space.

Each request carries an access kind. Instruction fetches use the code base and stack accesses use the stack base. Extra accesses use the extra base. Data accesses use the data base unless an override names another segment. Interrupt-vector requests ignore the segments and give the start of the 4-byte entry for the vector number. The segment bases are loaded through a simple write port. The code base resets to all ones, so a fetch at offset zero after reset lands at FFFF0H. The result is registered and flagged by a one-cycle valid strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it rises until the first request, valid_o is 0 and addr_o is 00000H. Reset sets the code base to FFFFH and the other three bases to 0000H, so a fetch at offset 0000H produces FFFF0H.
- R2: When seg_we_i is high at a clock edge, the base chosen by seg_wsel_i is loaded with seg_wdata_i. The encoding is 00 extra, 01 code, 10 stack, 11 data.
- R3: For segment-based kinds, addr_o = (base * 16 + offset_i) mod 2^20. A sum past FFFFFH wraps to the low end of the space.
- R4: Kind 000 (fetch) uses the code base. ovr_en_i has no effect on it.
- R5: Kind 010 (stack) uses the stack base. ovr_en_i has no effect on it.
- R6: Kind 001 (data) uses the data base when ovr_en_i is 0. When ovr_en_i is 1, it uses the base that ovr_sel_i selects, with the same encoding as R2.
- R7: Kind 011 (extra) uses the extra base. ovr_en_i has no effect on it.
- R8: Kind 100 (vector) gives addr_o = vec_num_i * 4, in the range 00000H to 003FCH. Offset, override and segment bases play no part.
- R9: A request sampled at a clock edge shows up on addr_o, with valid_o high, right after that edge. valid_o is high for exactly the cycles that follow an accepted request. addr_o holds its value while valid_o is low.
- R10: Kinds 101, 110 and 111 are rejected. They produce no valid_o, and addr_o keeps its previous value.
- R11: A request and a segment write in the same cycle: the request uses the base value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seg_we_i | input | 1 | Segment base write enable |
| seg_wsel_i | input | 2 | Segment to write (00 extra, 01 code, 10 stack, 11 data) |
| seg_wdata_i | input | 16 | New segment base |
| req_i | input | 1 | Address request strobe |
| req_kind_i | input | 3 | Access kind (000 fetch, 001 data, 010 stack, 011 extra, 100 vector) |
| offset_i | input | 16 | Offset within the segment |
| ovr_en_i | input | 1 | Segment override enable for data accesses |
| ovr_sel_i | input | 2 | Override segment, same encoding as seg_wsel_i |
| vec_num_i | input | 8 | Interrupt vector number |
| addr_o | output | 20 | Registered physical address |
| valid_o | output | 1 | addr_o holds the result of the previous cycle's request |

## Verification
Each address is due in the cycle right after the edge that samples its request. The bench drives every request on the falling edge, waits for one rising edge, and reads addr_o and valid_o one nanosecond later. It then checks that valid_o has dropped after the next rising edge. A segment write takes effect at the edge that samples it. Tests therefore place writes one full cycle before the request that relies on them, except in the same-cycle test. That test issues both together and expects the old base on the first result and the new base on the next one.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [2:0] {
    KIND_FETCH  = 3'b000,
    KIND_DATA   = 3'b001,
    KIND_STACK  = 3'b010,
    KIND_EXTRA  = 3'b011,
    KIND_VECTOR = 3'b100
  } access_kind_e;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_id_e;

  localparam int unsigned NUM_SEGS = 4;

  function automatic logic kind_is_legal(input logic [2:0] kind);
    return kind <= KIND_VECTOR;
  endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       wsel_i,
  input  logic [SEG_W-1:0] wdata_i,
  input  logic [1:0]       rsel_i,
  output logic [SEG_W-1:0] rdata_o
);

  logic [SEG_W-1:0] seg_q [NUM_SEGS];

  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
    // code base resets high so the first fetch lands at the top of memory
    localparam logic [SEG_W-1:0] RST_VAL = (i == int'(SEG_CODE)) ? '1 : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seg_q[i] <= RST_VAL;
      end else if (we_i && (wsel_i == 2'(i))) begin
        seg_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_o = seg_q[rsel_i];

endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_addr_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       ovr_en_i,
  input  logic [1:0] ovr_sel_i,
  output logic [1:0] seg_o
);

  always_comb begin
    unique case (kind_i)
      KIND_FETCH: seg_o = SEG_CODE;
      KIND_STACK: seg_o = SEG_STACK;
      KIND_EXTRA: seg_o = SEG_EXTRA;
      KIND_DATA:  seg_o = ovr_en_i ? ovr_sel_i : SEG_DATA;
      default:    seg_o = SEG_DATA;
    endcase
  end

endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned SHIFT = ADDR_W - SEG_W;

  logic [ADDR_W-1:0] base_ext;
  logic [ADDR_W-1:0] off_ext;

  assign base_ext = {seg_i, {SHIFT{1'b0}}};
  assign off_ext  = {{(ADDR_W-OFF_W){1'b0}}, off_i};
  // carry out of the top bit is dropped: wrap modulo 2^ADDR_W
  assign addr_o   = base_ext + off_ext;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_we_i,
  input  logic [1:0]        seg_wsel_i,
  input  logic [SEG_W-1:0]  seg_wdata_i,
  input  logic              req_i,
  input  logic [2:0]        req_kind_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              ovr_en_i,
  input  logic [1:0]        ovr_sel_i,
  input  logic [VEC_W-1:0]  vec_num_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);

  localparam int unsigned VEC_ENTRY_LG = 2;
  localparam int unsigned VEC_PAD      = ADDR_W - VEC_W - VEC_ENTRY_LG;

  logic [1:0]        seg_sel;
  logic [SEG_W-1:0]  seg_val;
  logic [ADDR_W-1:0] seg_addr;
  logic [ADDR_W-1:0] vec_addr;
  logic [ADDR_W-1:0] addr_d;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;

  seg_pick u_pick (
    .kind_i    (req_kind_i),
    .ovr_en_i  (ovr_en_i),
    .ovr_sel_i (ovr_sel_i),
    .seg_o     (seg_sel)
  );

  seg_bank #(.SEG_W(SEG_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (seg_we_i),
    .wsel_i  (seg_wsel_i),
    .wdata_i (seg_wdata_i),
    .rsel_i  (seg_sel),
    .rdata_o (seg_val)
  );

  phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_add (
    .seg_i  (seg_val),
    .off_i  (offset_i),
    .addr_o (seg_addr)
  );

  assign vec_addr = {{VEC_PAD{1'b0}}, vec_num_i, {VEC_ENTRY_LG{1'b0}}};
  assign addr_d   = (req_kind_i == KIND_VECTOR) ? vec_addr : seg_addr;
  assign accept   = req_i && kind_is_legal(req_kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= accept;
      if (accept) addr_q <= addr_d;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned VEC_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [2:0]        req_kind_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic [VEC_W-1:0]  vec_num_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o
);

  // R9
  accept_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_kind_i <= 3'd4) |=> valid_o);

  // R10
  reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && req_kind_i <= 3'd4) |=> !valid_o);

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(addr_o));

  // R3
  low_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_kind_i <= 3'd3) |=> addr_o[3:0] == $past(offset_i[3:0]));

  // R8
  vec_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_kind_i == 3'd4) |=>
      (addr_o[ADDR_W-1:VEC_W+2] == '0) && (addr_o[1:0] == 2'b00)
      && (addr_o[VEC_W+1:2] == $past(vec_num_i)));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .OFF_W(OFF_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .req_kind_i (req_kind_i),
  .offset_i   (offset_i),
  .vec_num_i  (vec_num_i),
  .addr_o     (addr_o),
  .valid_o    (valid_o)
);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/100ps
module sim_seg_addr_gen;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seg_we_i = 1'b0;
  logic [1:0]  seg_wsel_i = '0;
  logic [15:0] seg_wdata_i = '0;
  logic        req_i = 1'b0;
  logic [2:0]  req_kind_i = '0;
  logic [15:0] offset_i = '0;
  logic        ovr_en_i = 1'b0;
  logic [1:0]  ovr_sel_i = '0;
  logic [7:0]  vec_num_i = '0;
  logic [19:0] addr_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  seg_addr_gen u0 (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_wsel_i = sel; seg_wdata_i = val;
    @(negedge clk_i);
    seg_we_i = 1'b0;
  endtask

  // one request; result checked one cycle later, then valid must drop
  task automatic issue(input logic [2:0] kind, input logic [15:0] off,
                       input logic oe, input logic [1:0] os, input logic [7:0] vec,
                       input logic [19:0] exp, input string what);
    @(negedge clk_i);
    req_i = 1'b1; req_kind_i = kind; offset_i = off;
    ovr_en_i = oe; ovr_sel_i = os; vec_num_i = vec;
    @(posedge clk_i); #1;
    chk(32'(valid_o), 32'd1, {what, " valid"});
    chk(32'(addr_o), 32'(exp), {what, " addr"});
    @(negedge clk_i);
    req_i = 1'b0; ovr_en_i = 1'b0;
    @(posedge clk_i); #1;
    chk(32'(valid_o), 32'd0, {what, " valid drop"});
    chk(32'(addr_o), 32'(exp), {what, " addr hold"});
  endtask

  task automatic t_reset;
    #1;
    chk(32'(valid_o), 32'd0, "R1 valid in reset");
    chk(32'(addr_o), 32'd0, "R1 addr in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(32'(valid_o), 32'd0, "R1 valid after reset");
    issue(3'b000, 16'h0000, 1'b1, 2'b11, 8'h00, 20'hFFFF0, "R1 R4 boot fetch");
  endtask

  task automatic t_load;
    wr_seg(2'b01, 16'h0800);
    wr_seg(2'b11, 16'h2A40);
    wr_seg(2'b10, 16'h7F00);
    wr_seg(2'b00, 16'h5000);
    issue(3'b000, 16'h0004, 1'b0, 2'b00, 8'h00, 20'h08004, "R2 R4 fetch code");
    issue(3'b001, 16'h3C15, 1'b0, 2'b00, 8'h00, 20'h2E015, "R2 R3 data");
  endtask

  task automatic t_wrap;
    wr_seg(2'b01, 16'hFFFF);
    issue(3'b000, 16'h0020, 1'b0, 2'b00, 8'h00, 20'h00010, "R3 wrap");
    issue(3'b011, 16'hFFFF, 1'b0, 2'b00, 8'h00, 20'h5FFFF, "R3 R7 extra max off");
  endtask

  task automatic t_override;
    issue(3'b001, 16'h0010, 1'b1, 2'b00, 8'h00, 20'h50010, "R6 ovr extra");
    issue(3'b001, 16'h0010, 1'b1, 2'b10, 8'h00, 20'h7F010, "R6 ovr stack");
    issue(3'b001, 16'h0010, 1'b1, 2'b01, 8'h00, 20'h00000, "R6 ovr code");
  endtask

  task automatic t_no_ovr;
    issue(3'b010, 16'h0102, 1'b1, 2'b11, 8'h00, 20'h7F102, "R5 stack ignores ovr");
    issue(3'b011, 16'h0001, 1'b1, 2'b10, 8'h00, 20'h50001, "R7 extra ignores ovr");
  endtask

  task automatic t_vector;
    issue(3'b100, 16'h1234, 1'b1, 2'b01, 8'h21, 20'h00084, "R8 vector 21h");
    issue(3'b100, 16'hFFFF, 1'b0, 2'b00, 8'hFF, 20'h003FC, "R8 vector FFh");
    issue(3'b100, 16'h0000, 1'b0, 2'b00, 8'h00, 20'h00000, "R8 vector 0");
  endtask

  task automatic t_reserved;
    issue(3'b010, 16'h0000, 1'b0, 2'b00, 8'h00, 20'h7F000, "R10 setup");
    for (int k = 5; k < 8; k++) begin
      @(negedge clk_i);
      req_i = 1'b1; req_kind_i = 3'(k); offset_i = 16'hABCD;
      @(posedge clk_i); #1;
      chk(32'(valid_o), 32'd0, "R10 reserved no valid");
      chk(32'(addr_o), 32'h7F000, "R10 reserved addr held");
      @(negedge clk_i); req_i = 1'b0;
    end
  endtask

  task automatic t_same_cycle;
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_wsel_i = 2'b11; seg_wdata_i = 16'h1000;
    req_i = 1'b1; req_kind_i = 3'b001; offset_i = 16'h0000; ovr_en_i = 1'b0;
    @(posedge clk_i); #1;
    chk(32'(valid_o), 32'd1, "R11 valid");
    chk(32'(addr_o), 32'h2A400, "R11 old base used");
    @(negedge clk_i); seg_we_i = 1'b0;
    @(posedge clk_i); #1;
    chk(32'(valid_o), 32'd1, "R9 back-to-back valid");
    chk(32'(addr_o), 32'h10000, "R11 R2 new base next");
    @(negedge clk_i); req_i = 1'b0;
    @(posedge clk_i); #1;
    chk(32'(valid_o), 32'd0, "R9 pulse ends");
  endtask

  initial begin
    t_reset();
    t_load();
    t_wrap();
    t_override();
    t_no_ovr();
    t_vector();
    t_reserved();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule